// File: doc/BRIEF.md
# Configurable NMI Trigger Latch

This block conditions one external non-maskable interrupt pin and turns it into a single held request for a downstream primary interrupt controller. The pin is first brought into the clock domain through a two-flop synchronizer. A software-selected trigger type then decides what counts as an event: a high level, a low level, a rising edge or a falling edge. Every qualifying event sets a sticky pending latch. This latch sits after the detector, so a short level pulse still leaves a request behind.

The latch stays set after the pin has gone back to idle. It only clears when software writes a one to the pending bit. The latched request is offered twice. One copy is gated by an enable bit and drives the primary controller. The other copy is not gated and serves as source 0 of a secondary interrupt controller, which applies its own masking. Software reaches the block through a plain port made of valid, write, address, write data and combinational read data.

Top module: `nmi_trig_latch`

## Requirements
- R1: After reset the pending latch reads 0, both request outputs are low, the trigger-select register reads 3 (rising edge) and the enable reads 0.
- R2: The trigger select is bits [1:0] at word address 0, encoded 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. It reads back as written.
- R3: A pin change becomes visible at `src0_req` on the third rising clock edge after it is applied, because it passes two synchronizer flops and then the latch. The outputs are unchanged on the second edge.
- R4: In rising-edge mode a low-to-high pin transition sets the latch.
- R5: In falling-edge mode a high-to-low transition sets the latch, and a low-to-high transition does not.
- R6: In high-level mode a high pin sets the latch. In low-level mode a low pin sets the latch.
- R7: The latch stays set after the pin returns to its idle level, until it is acknowledged.
- R8: Writing 1 to bit 0 of word address 1 clears the latch at the next clock edge. Writing 0 there leaves it unchanged. Reading address 1 returns the latch in bit 0.
- R9: An edge event in the same cycle as an acknowledge leaves the latch set.
- R10: In level mode, an acknowledge while the active level is still present clears the latch for exactly one cycle, and the latch then sets again.
- R11: The enable (bit 0 of word address 2) gates `irq_req` only. While it is disabled, events still set the latch and `src0_req`. Setting the enable then raises `irq_req` at the next edge.
- R12: An edge that the detector sees in the same cycle as a write to the trigger select does not set the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Raw external interrupt pin, asynchronous |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Enable-gated request to the primary controller |
| src0_req | output | 1 | Ungated latched request, source 0 of the secondary controller |

## Verification
Results arrive at fixed distances from the stimulus. A pin change reaches the outputs three edges after it is applied. An acknowledge or an enable write takes effect one edge after the write strobe. A trigger-select write has its effect at the following edge, and a level condition is then latched one edge later. The driver stamps each expected output pair with the cycle number in which it is due. It also pushes the value expected one cycle before the due cycle, so that early changes are caught. The monitor compares each item only in its stamped cycle, at the falling clock edge. For R9 and R12 the driver waits exactly two edges after the pin change before it raises the write strobe, so that the write coincides with the detector's edge cycle.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_PEND = 1;
  localparam int unsigned ADDR_EN   = 2;

  // Bit 1 of the encoding separates edge modes from level modes.
  function automatic logic f_is_edge(input trig_e t);
    return t[1];
  endfunction

  function automatic logic f_hit(input trig_e t, input logic cur, input logic prv);
    logic r;
    case (t)
      TRIG_LOW:  r = ~cur;
      TRIG_HIGH: r = cur;
      TRIG_FALL: r = prv & ~cur;
      default:   r = cur & ~prv;
    endcase
    return r;
  endfunction

  // Set has priority over clear.
  function automatic logic f_latch_next(input logic held, input logic set, input logic clr);
    return set | (held & ~clr);
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_s,
  input  nmi_pkg::trig_e trig,
  input  logic          cfg_wr,
  input  logic          ack_wr,
  output logic          evt
);
  import nmi_pkg::*;

  logic prev_q;
  logic hit;
  logic edge_mode;

  // The delayed copy reloads from the synchronized pin every cycle, the
  // trigger-select write cycle included. Masking that cycle is therefore
  // enough to keep a mode change from producing a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign edge_mode = f_is_edge(trig);
  assign hit       = f_hit(trig, pin_s, prev_q);

  // Edge events are dropped while the trigger select is written. Level
  // events are held off during an acknowledge so that the latch drops
  // for one cycle before it sets again.
  assign evt = hit & ~(edge_mode & cfg_wr) & ~(~edge_mode & ack_wr);
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs #(
  parameter int unsigned   ADDR_W     = 4,
  parameter int unsigned   DATA_W     = 32,
  parameter nmi_pkg::trig_e RESET_TRIG = nmi_pkg::TRIG_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              evt,
  output logic [DATA_W-1:0] reg_rdata,
  output nmi_pkg::trig_e    trig_q,
  output logic              en_q,
  output logic              pend_q,
  output logic              cfg_wr,
  output logic              ack_wr
);
  import nmi_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_EN);

  logic wr_any;
  logic en_wr;
  logic unused_wdata;

  assign wr_any       = reg_valid & reg_write;
  assign cfg_wr       = wr_any & (reg_addr == A_CTRL);
  assign en_wr        = wr_any & (reg_addr == A_EN);
  assign ack_wr       = wr_any & (reg_addr == A_PEND) & reg_wdata[0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= RESET_TRIG;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cfg_wr) trig_q <= trig_e'(reg_wdata[1:0]);
      if (en_wr)  en_q   <= reg_wdata[0];
      pend_q <= f_latch_next(pend_q, evt, ack_wr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1:0] = trig_q;
      A_PEND:  reg_rdata[0]   = pend_q;
      A_EN:    reg_rdata[0]   = en_q;
      default: reg_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/nmi_trig_latch.sv
module nmi_trig_latch #(
  parameter int unsigned    ADDR_W      = 4,
  parameter int unsigned    DATA_W      = 32,
  parameter int unsigned    SYNC_STAGES = 2,
  parameter nmi_pkg::trig_e RESET_TRIG  = nmi_pkg::TRIG_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic              src0_req
);
  import nmi_pkg::*;

  logic  pin_s;
  logic  evt;
  logic  cfg_wr;
  logic  ack_wr;
  logic  en_q;
  logic  pend_q;
  trig_e trig_q;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(nmi_pin), .sync_out(pin_s)
  );

  nmi_detect u_detect (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .trig(trig_q),
    .cfg_wr(cfg_wr), .ack_wr(ack_wr), .evt(evt)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_TRIG(RESET_TRIG)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt(evt),
    .reg_rdata(reg_rdata), .trig_q(trig_q), .en_q(en_q), .pend_q(pend_q),
    .cfg_wr(cfg_wr), .ack_wr(ack_wr)
  );

  assign src0_req = pend_q;
  assign irq_req  = pend_q & en_q;
endmodule

// File: rtl/nmi_trig_latch_chk.sv
module nmi_trig_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt,
  input logic       cfg_wr,
  input logic       ack_wr,
  input logic       en_q,
  input logic [1:0] trig_q,
  input logic       irq_req,
  input logic       src0_req
);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src0_req && !ack_wr) |=> src0_req);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !evt) |=> !src0_req);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> src0_req);

  p_level_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !trig_q[1]) |=> !src0_req);

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (src0_req && en_q));

  p_cfg_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && trig_q[1] && !src0_req) |=> !src0_req);
endmodule

bind nmi_trig_latch nmi_trig_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .cfg_wr(cfg_wr), .ack_wr(ack_wr),
  .en_q(en_q), .trig_q(trig_q), .irq_req(irq_req), .src0_req(src0_req)
);

// File: tb/nmi_trig_latch_tb.sv
module nmi_trig_latch_tb;
  localparam int AW = 4;
  localparam int DW = 32;

  typedef struct {
    int    due;
    logic  s0;
    logic  irq;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nmi_pin = 1'b0;
  logic          reg_valid = 1'b0;
  logic          reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_req;
  logic          src0_req;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nmi_trig_latch u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .src0_req(src0_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_out(input int dly, input logic s0, input logic irq, input string tag);
    exp_t e;
    e.due = cyc + dly; e.s0 = s0; e.irq = irq; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each item at the falling edge of its due cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check({src0_req, irq_req} === {e.s0, e.irq}, e.tag,
            {src0_req, irq_req}, {e.s0, e.irq});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_valid = 1'b1; reg_write = 1'b1;
    reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = AW'(a);
    #1;
    check(reg_rdata === DW'(exp), tag, int'(reg_rdata), exp);
  endtask

  task automatic ack;
    expect_out(1, 1'b0, 1'b0, "R8 ack clears");
    wr(1, 1);
    idle(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 default encoding
    rd(0, 3, "R1 trig reset"); rd(1, 0, "R1 pend reset"); rd(2, 0, "R1 en reset");
    expect_out(1, 1'b0, 1'b0, "R1 outputs reset");
    idle(2);
    wr(2, 1);
    rd(2, 1, "R11 enable readback");

    // R3 latency, R4 rising edge
    nmi_pin = 1'b1;
    expect_out(2, 1'b0, 1'b0, "R3 not before third edge");
    expect_out(3, 1'b1, 1'b1, "R4 rising sets (R3 third edge)");
    idle(5);
    rd(1, 1, "R8 pend reads 1");
    // R7 sticky after pin idles
    nmi_pin = 1'b0;
    expect_out(4, 1'b1, 1'b1, "R7 held after pin idle");
    idle(5);
    // R8 write 0 no effect, write 1 clears
    expect_out(1, 1'b1, 1'b1, "R8 write 0 ignored");
    wr(1, 0);
    idle(2);
    ack();
    rd(1, 0, "R8 pend reads 0");

    // R5 falling edge mode
    wr(0, 2);
    rd(0, 2, "R2 falling readback");
    idle(3);
    nmi_pin = 1'b1;
    expect_out(4, 1'b0, 1'b0, "R5 rise ignored");
    idle(5);
    nmi_pin = 1'b0;
    expect_out(2, 1'b0, 1'b0, "R5 not before third edge");
    expect_out(3, 1'b1, 1'b1, "R5 falling sets");
    idle(5);
    ack();

    // R11 enable gating
    wr(2, 0);
    nmi_pin = 1'b1;
    idle(5);
    nmi_pin = 1'b0;
    expect_out(3, 1'b1, 1'b0, "R11 latched while disabled");
    idle(5);
    rd(1, 1, "R11 pend recorded");
    expect_out(1, 1'b1, 1'b1, "R11 enable raises irq");
    wr(2, 1);
    idle(2);
    ack();

    // R6 high level, R10 re-arm
    wr(0, 1);
    rd(0, 1, "R2 high readback");
    nmi_pin = 1'b1;
    expect_out(3, 1'b1, 1'b1, "R6 high level sets");
    idle(5);
    expect_out(1, 1'b0, 1'b0, "R10 drop one cycle");
    expect_out(2, 1'b1, 1'b1, "R10 sets again");
    wr(1, 1);
    idle(4);
    nmi_pin = 1'b0;
    idle(4);
    ack();

    // R6 low level
    expect_out(1, 1'b0, 1'b0, "R6 low not yet");
    expect_out(2, 1'b1, 1'b1, "R6 low level sets");
    wr(0, 0);
    rd(0, 0, "R2 low readback");
    idle(3);
    nmi_pin = 1'b1;
    idle(4);
    ack();

    // R9 edge coincides with ack
    wr(0, 3);
    nmi_pin = 1'b0;
    idle(4);
    nmi_pin = 1'b1;
    expect_out(3, 1'b1, 1'b1, "R9 first set");
    idle(5);
    nmi_pin = 1'b0;
    idle(4);
    nmi_pin = 1'b1;
    idle(2);
    expect_out(1, 1'b1, 1'b1, "R9 set wins over ack");
    expect_out(3, 1'b1, 1'b1, "R9 still set");
    wr(1, 1);
    idle(4);
    ack();

    // R12 edge coincides with trigger-select write
    nmi_pin = 1'b0;
    idle(4);
    nmi_pin = 1'b1;
    idle(2);
    expect_out(1, 1'b0, 1'b0, "R12 no latch on cfg write");
    expect_out(4, 1'b0, 1'b0, "R12 no late edge");
    wr(0, 3);
    idle(6);

    while (sb.size() > 0) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end
endmodule